// File: doc/BRIEF.md
# EDO DRAM Power-Up and Refresh Sequencer

This block belongs to the memory controller of an asynchronous EDO DRAM. It owns every refresh cycle the controller issues. After reset it waits out the power-up pause. It then runs the wake-up burst of refresh cycles and reports the memory ready. From then on it schedules periodic refreshes. All analog timing is given as counts of the system clock.

Each refresh cycle needs the memory bus. The sequencer raises a request to the bus arbiter and waits for a grant. It then drives the strobes and pulses a completion flag in the last clock of the cycle. Two refresh styles are offered:
- **Internal-counter style:** the column strobe falls before the row strobe, and the device supplies the row itself.
- **Row-addressed style:** the block drives the row from a counter of its own. This style has a shorter request interval, because it must cover twice as many rows in the same retention window.

Requests that the arbiter does not serve at once are banked. Once enough are banked, the block flags them as urgent. If the bank overflows, the retention deadline is considered missed: ready is withdrawn and the full wake-up burst is replayed.

Top module: `edo_refresh_seq`

## Requirements
- R1: While `rst_n` is low, `ras_n`, `cas_n` and `we_n` are high, and `ready`, `ref_req`, `ref_urgent` and `row_oe` are low.
- R2: After reset is released, `ref_req` stays low for exactly `PAUSE_CYC` clock cycles and rises in the cycle that follows them.
- R3: After the pause, exactly `WAKE_CNT` refresh cycles run with `we_n` high. `ready` stays low until the clock edge that ends the last of them, and is high from that edge on.
- R4: An internal-counter refresh (`mode_ras_only` = 0 when granted) runs in three phases, with `row_oe` low throughout:
  - `cas_n` low with `ras_n` high for `CBR_LEAD` cycles;
  - both strobes low for `RAS_LOW` cycles;
  - both high for `RAS_PRE` cycles, with `ref_done` high only in the last of these.
- R5: A row-addressed refresh (`mode_ras_only` = 1 when granted) keeps `cas_n` high throughout. It drives `ras_n` low with `row_oe` high for `RAS_LOW` cycles, then precharges for `RAS_PRE` cycles, with `ref_done` high in the last of these.
- R6: Successive row-addressed refreshes present rows 0, 1, 2, … on `row_addr`, counting from reset and wrapping at 2^`ROW_W`. Internal-counter refreshes do not advance the row.
- R7: `ref_req` holds high and both strobes stay high until `gnt` is seen with `ref_req`. The refresh starts on that clock edge.
- R8: Once `ready` rises, the first periodic request appears exactly `INT_CBR` cycles later in internal-counter mode, or `INT_ROW` cycles later in row-addressed mode.
- R9: Each interval adds one owed refresh, and each completed refresh retires one. `ref_urgent` is high while `POSTPONE_MAX` or more are owed.
- R10: An interval that ends while `DEBT_MAX` refreshes are already owed has three effects:
  - `ready` drops after that edge;
  - the owed count is discarded;
  - `WAKE_CNT` wake-up refreshes are requested at once, with no pause, after which `ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ras_only | input | 1 | 1 selects row-addressed refresh and its interval, 0 selects internal-counter refresh |
| gnt | input | 1 | Bus grant from the arbiter |
| ref_req | output | 1 | Bus request for a refresh cycle |
| ref_urgent | output | 1 | Banked refreshes have reached the postponement limit |
| ref_done | output | 1 | High in the final clock of a refresh cycle |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high for refresh |
| row_addr | output | ROW_W | Refresh row for row-addressed cycles |
| row_oe | output | 1 | `row_addr` is valid and must be driven onto the address bus |
| ready | output | 1 | Initialization complete and deadline kept |

## Verification
The strobes follow from the state register, so they change in the first cycle after the granting edge. `ref_done` is high in the last precharge cycle. `ready` and `ref_req` move one edge after the event that sets them: the edge that completes the last wake-up refresh, or the edge that completes an interval.

The bench drives and samples only on falling edges and steps a known number of cycles before each check:
- it measures the pause and the request interval as counts from a defined falling edge;
- it measures the width of each strobe phase by sampling every cycle of a refresh;
- it places the urgency and missed-deadline checks one cycle before and exactly at the interval edges where the owed count is due to change.

// File: rtl/edo_refresh_seq.sv
module edo_refresh_seq #(
  parameter int PAUSE_CYC    = 10000,
  parameter int WAKE_CNT     = 8,
  parameter int INT_CBR      = 1560,
  parameter int INT_ROW      = 780,
  parameter int RAS_LOW      = 5,
  parameter int RAS_PRE      = 4,
  parameter int CBR_LEAD     = 2,
  parameter int POSTPONE_MAX = 4,
  parameter int DEBT_MAX     = 8,
  parameter int ROW_W        = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_ras_only,
  input  logic             gnt,
  output logic             ref_req,
  output logic             ref_urgent,
  output logic             ref_done,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] row_addr,
  output logic             row_oe,
  output logic             ready
);

  localparam int IMAX = (INT_CBR > INT_ROW) ? INT_CBR : INT_ROW;
  localparam int PH1  = (RAS_LOW > RAS_PRE) ? RAS_LOW : RAS_PRE;
  localparam int PHM  = (PH1 > CBR_LEAD) ? PH1 : CBR_LEAD;
  localparam int PW   = $clog2(PAUSE_CYC + 1);
  localparam int IW   = $clog2(IMAX + 1);
  localparam int CW   = $clog2(PHM + 1);
  localparam int DW   = $clog2(DEBT_MAX + 2);
  localparam int WW   = $clog2(WAKE_CNT + 1);

  typedef enum logic [2:0] {S_PAUSE, S_IDLE, S_LEAD, S_RAS, S_PRE} st_t;

  st_t             st;
  logic [PW-1:0]   pcnt;
  logic [CW-1:0]   ph;
  logic [IW-1:0]   tmr;
  logic [DW-1:0]   pend;
  logic [WW-1:0]   wake;
  logic            ready_q, ro_q;
  logic [ROW_W-1:0] row_q;

  logic [IW-1:0] int_lim;
  logic pause_end, need, start, tick, miss, fin;

  assign pause_end = (st == S_PAUSE) && (pcnt == PW'(PAUSE_CYC - 1));
  assign need      = (wake != '0) || (pend != '0);
  assign start     = ref_req && gnt;
  assign int_lim   = mode_ras_only ? IW'(INT_ROW - 1) : IW'(INT_CBR - 1);
  assign tick      = ready_q && (tmr >= int_lim);
  assign miss      = tick && (pend == DW'(DEBT_MAX));
  assign fin       = (st == S_PRE) && (ph == CW'(RAS_PRE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_PAUSE;
      pcnt  <= '0;
      ph    <= '0;
      ro_q  <= 1'b0;
      row_q <= '0;
    end else begin
      case (st)
        S_PAUSE: begin
          if (pause_end) st <= S_IDLE;
          else           pcnt <= pcnt + 1'b1;
        end
        S_IDLE: begin
          if (start) begin
            ro_q <= mode_ras_only;
            ph   <= '0;
            st   <= mode_ras_only ? S_RAS : S_LEAD;
          end
        end
        S_LEAD: begin
          if (ph == CW'(CBR_LEAD - 1)) begin
            ph <= '0;
            st <= S_RAS;
          end else ph <= ph + 1'b1;
        end
        S_RAS: begin
          if (ph == CW'(RAS_LOW - 1)) begin
            ph <= '0;
            st <= S_PRE;
            if (ro_q) row_q <= row_q + 1'b1;
          end else ph <= ph + 1'b1;
        end
        S_PRE: begin
          if (fin) begin
            ph <= '0;
            st <= S_IDLE;
          end else ph <= ph + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr     <= '0;
      pend    <= '0;
      wake    <= '0;
      ready_q <= 1'b0;
    end else begin
      tmr <= (!ready_q || tick) ? '0 : tmr + 1'b1;
      if (pause_end) begin
        wake <= WW'(WAKE_CNT);
      end else if (miss) begin
        pend    <= '0;
        wake    <= WW'(WAKE_CNT);
        ready_q <= 1'b0;
      end else begin
        if (fin && wake != '0) begin
          wake <= wake - 1'b1;
          if (wake == WW'(1)) ready_q <= 1'b1;
        end
        pend <= pend + DW'(tick) - DW'(fin && wake == '0 && pend != '0);
      end
    end
  end

  assign ref_req    = (st == S_IDLE) && need;
  assign ref_urgent = pend >= DW'(POSTPONE_MAX);
  assign ref_done   = fin;
  assign ras_n      = (st != S_RAS);
  assign cas_n      = !((st == S_LEAD) || (st == S_RAS && !ro_q));
  assign we_n       = 1'b1;
  assign row_addr   = row_q;
  assign row_oe     = (st == S_RAS) && ro_q;
  assign ready      = ready_q;

endmodule

// File: rtl/edo_refresh_chk.sv
module edo_refresh_chk #(
  parameter int PAUSE_CYC = 10000,
  parameter int ROW_W     = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gnt,
  input logic             ref_req,
  input logic             ref_urgent,
  input logic             ref_done,
  input logic             ras_n,
  input logic             cas_n,
  input logic [ROW_W-1:0] row_addr,
  input logic             row_oe,
  input logic             ready
);
  localparam int UW = $clog2(PAUSE_CYC + 1);

  logic [UW-1:0]    up_cnt;
  logic [ROW_W-1:0] last_row;
  logic             have_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_cnt   <= '0;
      last_row <= '0;
      have_row <= 1'b0;
    end else begin
      if (up_cnt != UW'(PAUSE_CYC)) up_cnt <= up_cnt + 1'b1;
      if (row_oe) begin
        last_row <= row_addr;
        have_row <= 1'b1;
      end
    end
  end

  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> up_cnt >= UW'(PAUSE_CYC)); // R2
  AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(ref_done)); // R3
  AST_CAS_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> row_oe || $past(!cas_n)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> !ref_done); // R4
  AST_ROW_NO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    row_oe |-> cas_n && !ras_n); // R5
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_oe) && have_row |-> row_addr == ROW_W'(last_row + 1'b1)); // R6
  AST_START_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n && cas_n) |-> $past(ref_req && gnt)); // R7
  AST_URGENT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> ready); // R9

endmodule

bind edo_refresh_seq edo_refresh_chk #(.PAUSE_CYC(PAUSE_CYC), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gnt(gnt), .ref_req(ref_req), .ref_urgent(ref_urgent),
  .ref_done(ref_done), .ras_n(ras_n), .cas_n(cas_n), .row_addr(row_addr),
  .row_oe(row_oe), .ready(ready)
);

// File: tb/tb_edo_refresh_seq.sv
module tb_edo_refresh_seq;
  localparam int PAUSE = 20, WAKE = 8, ICBR = 40, IROW = 30;
  localparam int RLOW = 3, RPRE = 2, LEAD = 2, PMAX = 2, DMAX = 4, RW = 4;
  // bit 3: row-addressed mode, bits 2:0: grant delay in cycles
  localparam logic [3:0] VEC [0:5] = '{4'b0000, 4'b1000, 4'b1011, 4'b0010, 4'b1001, 4'b1101};

  logic clk = 0, rst_n = 0, mode = 0, gnt = 0;
  logic ref_req, ref_urgent, ref_done, ras_n, cas_n, we_n, row_oe, ready;
  logic [RW-1:0] row_addr;
  int checks = 0, errors = 0;
  int exp_row = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  edo_refresh_seq #(.PAUSE_CYC(PAUSE), .WAKE_CNT(WAKE), .INT_CBR(ICBR), .INT_ROW(IROW),
    .RAS_LOW(RLOW), .RAS_PRE(RPRE), .CBR_LEAD(LEAD), .POSTPONE_MAX(PMAX),
    .DEBT_MAX(DMAX), .ROW_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .mode_ras_only(mode), .gnt(gnt), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .ref_done(ref_done), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .row_addr(row_addr), .row_oe(row_oe), .ready(ready));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_refresh(input logic ro, input int dly, input bit exp_ready);
    int n = 0;
    int lead = 0, rasw = 0, casr = 0, roe = 0, pre = 0, rowbad = 0, webad = 0;
    bit seen = 0;
    mode = ro;
    while (!ref_req && n < 500) begin step(); n++; end
    chk(ref_req, "R7 request present", ref_req, 1);
    for (int k = 0; k < dly; k++) begin
      chk(ref_req && ras_n && cas_n, "R7 held until grant", {ref_req, ras_n, cas_n}, 7);
      step();
    end
    gnt = 1;
    step();
    gnt = 0;
    for (int k = 0; k < 40 && !seen; k++) begin
      if (!cas_n && ras_n) lead++;
      if (!ras_n) rasw++;
      if (!ras_n && !cas_n) casr++;
      if (row_oe) begin
        roe++;
        if (row_addr != RW'(exp_row)) rowbad++;
      end
      if (ras_n && cas_n) pre++;
      if (!we_n) webad++;
      if (ref_done) begin
        seen = 1;
        chk(ready == exp_ready, "R3 ready during cycle", ready, exp_ready);
      end else step();
    end
    chk(seen, "R4 done pulse", seen, 1);
    chk(webad == 0, "R3 we_n high", webad, 0);
    chk(rasw == RLOW, ro ? "R5 ras width" : "R4 ras width", rasw, RLOW);
    chk(pre == RPRE, ro ? "R5 precharge" : "R4 precharge", pre, RPRE);
    if (ro) begin
      chk(lead == 0 && casr == 0, "R5 cas high", lead + casr, 0);
      chk(roe == RLOW, "R5 row_oe width", roe, RLOW);
      chk(rowbad == 0, "R6 row value", row_addr, exp_row);
      exp_row = (exp_row + 1) % (1 << RW);
    end else begin
      chk(lead == LEAD, "R4 cas lead", lead, LEAD);
      chk(casr == RLOW, "R4 cas during ras", casr, RLOW);
      chk(roe == 0, "R4 no row drive", roe, 0);
    end
    step();
  endtask

  initial begin
    int n;
    step();
    step();
    chk(ras_n && cas_n && we_n, "R1 strobes idle", {ras_n, cas_n, we_n}, 7);
    chk(!ready && !ref_req && !ref_urgent && !row_oe, "R1 flags low",
        {ready, ref_req, ref_urgent, row_oe}, 0);
    rst_n = 1;
    n = 0;
    while (!ref_req && n < 1000) begin step(); n++; end
    chk(n == PAUSE, "R2 pause length", n, PAUSE);

    for (int w = 0; w < WAKE; w++) do_refresh(1'b0, 0, 1'b0);
    chk(ready, "R3 ready after wake-up", ready, 1);

    n = 0;
    while (!ref_req && n < 1000) begin step(); n++; end
    chk(n == ICBR, "R8 first interval internal mode", n, ICBR);

    for (int i = 0; i < 6; i++) do_refresh(VEC[i][3], int'(VEC[i][2:0]), 1'b1);

    mode = 0;
    while (ref_req) do_refresh(1'b0, 0, 1'b1);
    while (!ref_req) step();
    for (int k = 0; k < ICBR - 1; k++) step();
    chk(!ref_urgent, "R9 one owed not urgent", ref_urgent, 0);
    step();
    chk(ref_urgent, "R9 two owed urgent", ref_urgent, 1);
    do_refresh(1'b0, 0, 1'b1);
    chk(ref_req && !ref_urgent, "R9 one retired", {ref_req, ref_urgent}, 2);
    do_refresh(1'b0, 0, 1'b1);
    chk(!ref_req, "R9 all retired", ref_req, 0);

    while (!ref_req) step();
    for (int k = 0; k < DMAX * ICBR - 1; k++) step();
    chk(ready && ref_urgent, "R10 full bank still ready", {ready, ref_urgent}, 3);
    step();
    chk(!ready && ref_req && !ref_urgent, "R10 deadline missed",
        {ready, ref_req, ref_urgent}, 2);
    for (int w = 0; w < WAKE; w++) do_refresh(1'b1, 0, 1'b0);
    chk(ready, "R10 ready after replay", ready, 1);
    n = 0;
    while (!ref_req && n < 1000) begin step(); n++; end
    chk(n == IROW, "R8 first interval row mode", n, IROW);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule